// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block holds the operating mode of a CAN FD controller. It starts in configuration, and it waits there until the core is enabled and the bus has been idle for a run of eleven recessive bit times. It then moves into one of four active modes: normal, snoop, sleep or loopback. The mode is chosen from the request bits as they stand when configuration is left. Clearing the enable bit, asserting the soft reset or pulling the reset pin low sends it back to configuration from any mode.

While a mode is active the block also watches two fault conditions. When the transmit error count reaches the bus-off limit, the block enters bus-off. It leaves bus-off by counting a programmed number of idle runs. That counting starts at once when auto-recovery is set, and otherwise waits for a start pulse. A reported protocol exception, when not disabled, raises an exception flag that clears after the next idle run. Sleep mode is woken by a dominant bus sample. Bit timing, error counting and register access belong to other blocks. This block sees only the bit strobe, the sampled bus level and the register bits.

Top module: `canfd_mode_ctrl`

## Requirements
- R1: A low `rst_n`, a low `cfg_enable_i` or a high `soft_rst_i` puts the block in configuration in the next cycle. It also clears the bus-off and exception flags, and no interrupt is raised for that clearing.
- R2: Configuration is left only after 11 consecutive strobed samples with `bus_rx_i`=1 (recessive) while enabled. A strobed sample with `bus_rx_i`=0 (dominant) restarts the count, and the bus level has no effect while `bit_stb_i` is low. The mode flags change in the cycle after the 11th strobe.
- R3: On leaving configuration the mode is taken from the request bits with priority sleep > loopback > snoop. With no request bit set, the mode is normal.
- R4: Exactly one of `st_config_o`, `st_normal_o`, `st_snoop_o`, `st_sleep_o` and `st_loop_o` is high at all times.
- R5: Bus-off is entered only from an active mode, when `tx_err_cnt_i` >= 256. `st_busoff_o` rises one cycle later, together with a one-cycle `irq_busoff_on_o` pulse. A count of 255 does not cause entry, and no count causes entry while in configuration.
- R6: Without auto-recovery, bus-off lasts until a `recov_start_i` pulse arrives, however long the bus stays idle. With `recov_auto_i`=1, recovery counting begins on entry.
- R7: Recovery completes on the 128th run of 11 recessive strobed samples counted from the start of recovery. `st_busoff_o` falls and a one-cycle `irq_busoff_off_o` pulse appears in the cycle after the last strobe.
- R8: A `pex_event_i` in an active mode sets `st_pex_o`, with a one-cycle `irq_pex_o` pulse, one cycle later. This happens only when `pex_disable_i`=0. Nothing happens in configuration or when the exception is disabled.
- R9: `st_pex_o` clears in the cycle after the 11th consecutive recessive strobed sample counted from entry.
- R10: In sleep mode, a strobed dominant sample switches to normal mode and raises a one-cycle `irq_wake_o` pulse. A recessive sample keeps sleep.
- R11: Changes to the request bits outside configuration do not change the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable_i | input | 1 | Core enable bit |
| soft_rst_i | input | 1 | Soft reset request |
| req_loop_i | input | 1 | Loopback mode request |
| req_sleep_i | input | 1 | Sleep mode request |
| req_snoop_i | input | 1 | Snoop (listen-only) mode request |
| bit_stb_i | input | 1 | One-cycle strobe per nominal bit time |
| bus_rx_i | input | 1 | Sampled bus level, 1 = recessive |
| tx_err_cnt_i | input | TEC_W | Transmit error count |
| recov_start_i | input | 1 | Pulse that starts bus-off recovery |
| recov_auto_i | input | 1 | Start recovery automatically on bus-off |
| pex_disable_i | input | 1 | Disable protocol-exception entry |
| pex_event_i | input | 1 | Protocol exception detected |
| st_config_o | output | 1 | Configuration mode flag |
| st_normal_o | output | 1 | Normal mode flag |
| st_snoop_o | output | 1 | Snoop mode flag |
| st_sleep_o | output | 1 | Sleep mode flag |
| st_loop_o | output | 1 | Loopback mode flag |
| st_busoff_o | output | 1 | Bus-off or recovery in progress |
| st_pex_o | output | 1 | Protocol-exception state flag |
| irq_busoff_on_o | output | 1 | Pulse on bus-off entry |
| irq_busoff_off_o | output | 1 | Pulse on recovery completion |
| irq_pex_o | output | 1 | Pulse on exception entry |
| irq_wake_o | output | 1 | Pulse on wake from sleep |

## Verification
A forced return to configuration can fall in the same cycle as a bus-off entry. The bench provokes this by raising the soft reset in the very cycle the error count crosses the limit while normal mode is active. It judges the result by checking that configuration is reported next, with no bus-off flag and no entry interrupt. The same forced return is also applied in the middle of a bus-off that is waiting to recover. There the check is that the flag drops without a completion interrupt.

// File: rtl/canfd_mode_pkg.sv
package canfd_mode_pkg;

   typedef enum logic [2:0] {
      MODE_CFG    = 3'd0,
      MODE_NORMAL = 3'd1,
      MODE_SNOOP  = 3'd2,
      MODE_SLEEP  = 3'd3,
      MODE_LOOP   = 3'd4
   } op_mode_e;

   typedef enum logic [1:0] {
      BO_IDLE  = 2'd0,
      BO_WAIT  = 2'd1,
      BO_RECOV = 2'd2
   } bo_state_e;

   typedef struct packed {
      logic cfg;
      logic normal;
      logic snoop;
      logic sleep;
      logic loop;
   } mode_flags_t;

   function automatic mode_flags_t mode_to_flags(op_mode_e m);
      mode_flags_t f;
      f = '0;
      case (m)
         MODE_NORMAL: f.normal = 1'b1;
         MODE_SNOOP:  f.snoop  = 1'b1;
         MODE_SLEEP:  f.sleep  = 1'b1;
         MODE_LOOP:   f.loop   = 1'b1;
         default:     f.cfg    = 1'b1;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/canfd_run_detect.sv
module canfd_run_detect #(
   parameter int RUN_LEN = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic bit_stb_i,
   input  logic bus_rx_i,
   output logic run_done_o
);
   localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
   localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

   logic [RUN_W-1:0] cnt_q;

   assign run_done_o = bit_stb_i & bus_rx_i & ~clr_i & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (bit_stb_i) begin
         if (!bus_rx_i || cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/canfd_mode_select.sv
module canfd_mode_select
   import canfd_mode_pkg::*;
(
   input  logic     req_sleep_i,
   input  logic     req_loop_i,
   input  logic     req_snoop_i,
   output op_mode_e mode_o
);
   always_comb begin
      if (req_sleep_i)      mode_o = MODE_SLEEP;
      else if (req_loop_i)  mode_o = MODE_LOOP;
      else if (req_snoop_i) mode_o = MODE_SNOOP;
      else                  mode_o = MODE_NORMAL;
   end
endmodule

// File: rtl/canfd_busoff_ctrl.sv
module canfd_busoff_ctrl
   import canfd_mode_pkg::*;
#(
   parameter int TEC_W        = 9,
   parameter int BUSOFF_LIMIT = 256,
   parameter int RECOV_RUNS   = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_i,
   input  logic             active_i,
   input  logic [TEC_W-1:0] tec_i,
   input  logic             start_i,
   input  logic             auto_i,
   input  logic             run_done_i,
   output logic             busoff_o,
   output logic             restart_o,
   output logic             irq_on_o,
   output logic             irq_off_o
);
   localparam int OCC_W = (RECOV_RUNS > 1) ? $clog2(RECOV_RUNS) : 1;
   localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RECOV_RUNS - 1);
   localparam logic [TEC_W-1:0] LIMIT    = TEC_W'(BUSOFF_LIMIT);

   bo_state_e        st_q, st_d;
   logic [OCC_W-1:0] occ_q, occ_d;
   logic             enter, begin_rec, finish;

   assign enter     = ~force_i & active_i & (st_q == BO_IDLE) & (tec_i >= LIMIT);
   assign begin_rec = ~force_i & (st_q == BO_WAIT) & (start_i | auto_i);
   assign finish    = ~force_i & (st_q == BO_RECOV) & run_done_i & (occ_q == OCC_LAST);
   assign restart_o = enter | begin_rec;
   assign busoff_o  = (st_q != BO_IDLE);

   always_comb begin
      st_d  = st_q;
      occ_d = occ_q;
      if (force_i) begin
         st_d  = BO_IDLE;
         occ_d = '0;
      end else begin
         case (st_q)
            BO_IDLE: if (enter) begin
               st_d  = auto_i ? BO_RECOV : BO_WAIT;
               occ_d = '0;
            end
            BO_WAIT: if (begin_rec) begin
               st_d  = BO_RECOV;
               occ_d = '0;
            end
            BO_RECOV: if (run_done_i) begin
               if (finish) begin
                  st_d  = BO_IDLE;
                  occ_d = '0;
               end else begin
                  occ_d = occ_q + 1'b1;
               end
            end
            default: st_d = BO_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= BO_IDLE;
         occ_q     <= '0;
         irq_on_o  <= 1'b0;
         irq_off_o <= 1'b0;
      end else begin
         st_q      <= st_d;
         occ_q     <= occ_d;
         irq_on_o  <= enter;
         irq_off_o <= finish;
      end
   end
endmodule

// File: rtl/canfd_pex_ctrl.sv
module canfd_pex_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic force_i,
   input  logic active_i,
   input  logic event_i,
   input  logic disable_i,
   input  logic run_done_i,
   output logic pex_o,
   output logic restart_o,
   output logic irq_o
);
   logic enter;

   assign enter     = ~force_i & active_i & ~pex_o & event_i & ~disable_i;
   assign restart_o = enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pex_o <= 1'b0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= enter;
         if (force_i)                 pex_o <= 1'b0;
         else if (enter)              pex_o <= 1'b1;
         else if (pex_o & run_done_i) pex_o <= 1'b0;
      end
   end
endmodule

// File: rtl/canfd_mode_ctrl.sv
module canfd_mode_ctrl
   import canfd_mode_pkg::*;
#(
   parameter int TEC_W        = 9,
   parameter int BUSOFF_LIMIT = 256,
   parameter int RUN_LEN      = 11,
   parameter int RECOV_RUNS   = 128,
   parameter bit WAKE_ON_DOM  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable_i,
   input  logic             soft_rst_i,
   input  logic             req_loop_i,
   input  logic             req_sleep_i,
   input  logic             req_snoop_i,
   input  logic             bit_stb_i,
   input  logic             bus_rx_i,
   input  logic [TEC_W-1:0] tx_err_cnt_i,
   input  logic             recov_start_i,
   input  logic             recov_auto_i,
   input  logic             pex_disable_i,
   input  logic             pex_event_i,
   output logic             st_config_o,
   output logic             st_normal_o,
   output logic             st_snoop_o,
   output logic             st_sleep_o,
   output logic             st_loop_o,
   output logic             st_busoff_o,
   output logic             st_pex_o,
   output logic             irq_busoff_on_o,
   output logic             irq_busoff_off_o,
   output logic             irq_pex_o,
   output logic             irq_wake_o
);
   if (TEC_W < 2) begin : g_chk_tec_w
      $error("TEC_W must be at least 2");
   end
   if (BUSOFF_LIMIT < 1 || BUSOFF_LIMIT >= (1 << TEC_W)) begin : g_chk_limit
      $error("BUSOFF_LIMIT must fit in TEC_W bits");
   end
   if (RUN_LEN < 2) begin : g_chk_run
      $error("RUN_LEN must be at least 2");
   end
   if (RECOV_RUNS < 2) begin : g_chk_recov
      $error("RECOV_RUNS must be at least 2");
   end

   op_mode_e    mode_q, mode_d, sel_mode;
   mode_flags_t flags;
   logic        force_cfg, active, run_done, run_clr;
   logic        bo_restart, pex_restart, wake;
   logic        wake_irq_q;

   assign force_cfg = ~cfg_enable_i | soft_rst_i;
   assign active    = (mode_q != MODE_CFG);
   assign run_clr   = force_cfg | bo_restart | pex_restart;

   canfd_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (run_clr),
      .bit_stb_i  (bit_stb_i),
      .bus_rx_i   (bus_rx_i),
      .run_done_o (run_done)
   );

   canfd_mode_select u_sel (
      .req_sleep_i (req_sleep_i),
      .req_loop_i  (req_loop_i),
      .req_snoop_i (req_snoop_i),
      .mode_o      (sel_mode)
   );

   canfd_busoff_ctrl #(
      .TEC_W        (TEC_W),
      .BUSOFF_LIMIT (BUSOFF_LIMIT),
      .RECOV_RUNS   (RECOV_RUNS)
   ) u_bo (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_i    (force_cfg),
      .active_i   (active),
      .tec_i      (tx_err_cnt_i),
      .start_i    (recov_start_i),
      .auto_i     (recov_auto_i),
      .run_done_i (run_done),
      .busoff_o   (st_busoff_o),
      .restart_o  (bo_restart),
      .irq_on_o   (irq_busoff_on_o),
      .irq_off_o  (irq_busoff_off_o)
   );

   canfd_pex_ctrl u_pex (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_i    (force_cfg),
      .active_i   (active),
      .event_i    (pex_event_i),
      .disable_i  (pex_disable_i),
      .run_done_i (run_done),
      .pex_o      (st_pex_o),
      .restart_o  (pex_restart),
      .irq_o      (irq_pex_o)
   );

   if (WAKE_ON_DOM) begin : g_wake
      assign wake = ~force_cfg & (mode_q == MODE_SLEEP) & bit_stb_i & ~bus_rx_i;
   end else begin : g_no_wake
      assign wake = 1'b0;
   end

   always_comb begin
      mode_d = mode_q;
      if (force_cfg) begin
         mode_d = MODE_CFG;
      end else if (mode_q == MODE_CFG) begin
         if (run_done) mode_d = sel_mode;
      end else if (wake) begin
         mode_d = MODE_NORMAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_CFG;
         wake_irq_q <= 1'b0;
      end else begin
         mode_q     <= mode_d;
         wake_irq_q <= wake;
      end
   end

   assign flags       = mode_to_flags(mode_q);
   assign st_config_o = flags.cfg;
   assign st_normal_o = flags.normal;
   assign st_snoop_o  = flags.snoop;
   assign st_sleep_o  = flags.sleep;
   assign st_loop_o   = flags.loop;
   assign irq_wake_o  = wake_irq_q;
endmodule

// File: rtl/canfd_mode_ctrl_chk.sv
module canfd_mode_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_enable_i,
   input logic soft_rst_i,
   input logic bit_stb_i,
   input logic bus_rx_i,
   input logic pex_disable_i,
   input logic st_config_o,
   input logic st_normal_o,
   input logic st_snoop_o,
   input logic st_sleep_o,
   input logic st_loop_o,
   input logic st_busoff_o,
   input logic st_pex_o,
   input logic irq_busoff_on_o,
   input logic irq_busoff_off_o,
   input logic irq_pex_o,
   input logic irq_wake_o
);
   p_force_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_enable_i || soft_rst_i) |=> (st_config_o && !st_busoff_o && !st_pex_o));

   p_stay_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_config_o && !(bit_stb_i && bus_rx_i)) |=> st_config_o);

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({st_config_o, st_normal_o, st_snoop_o, st_sleep_o, st_loop_o}) == 1);

   p_busoff_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_busoff_o) |-> irq_busoff_on_o);

   p_no_busoff_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_config_o && !st_busoff_o) |=> !st_busoff_o);

   p_irq_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_busoff_on_o |=> !irq_busoff_on_o);

   p_recov_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(st_busoff_o) && $past(cfg_enable_i && !soft_rst_i)) |-> irq_busoff_off_o);

   p_recov_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_busoff_off_o |-> !st_busoff_o);

   p_pex_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pex_disable_i && !st_pex_o) |=> !st_pex_o);

   p_pex_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_pex_o) |-> irq_pex_o);

   p_wake_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wake_o |-> st_normal_o);

   p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_normal_o || st_snoop_o || st_loop_o) && cfg_enable_i && !soft_rst_i)
      |=> $stable({st_config_o, st_normal_o, st_snoop_o, st_sleep_o, st_loop_o}));
endmodule

bind canfd_mode_ctrl canfd_mode_ctrl_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_enable_i     (cfg_enable_i),
   .soft_rst_i       (soft_rst_i),
   .bit_stb_i        (bit_stb_i),
   .bus_rx_i         (bus_rx_i),
   .pex_disable_i    (pex_disable_i),
   .st_config_o      (st_config_o),
   .st_normal_o      (st_normal_o),
   .st_snoop_o       (st_snoop_o),
   .st_sleep_o       (st_sleep_o),
   .st_loop_o        (st_loop_o),
   .st_busoff_o      (st_busoff_o),
   .st_pex_o         (st_pex_o),
   .irq_busoff_on_o  (irq_busoff_on_o),
   .irq_busoff_off_o (irq_busoff_off_o),
   .irq_pex_o        (irq_pex_o),
   .irq_wake_o       (irq_wake_o)
);

// File: tb/canfd_mode_ctrl_test.sv
`timescale 1ns/1ps
module canfd_mode_ctrl_test;
   localparam int TEC_W = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable_i = 1'b0, soft_rst_i = 1'b0;
   logic req_loop_i = 1'b0, req_sleep_i = 1'b0, req_snoop_i = 1'b0;
   logic bit_stb_i = 1'b0, bus_rx_i = 1'b1;
   logic [TEC_W-1:0] tx_err_cnt_i = '0;
   logic recov_start_i = 1'b0, recov_auto_i = 1'b0;
   logic pex_disable_i = 1'b0, pex_event_i = 1'b0;
   logic st_config_o, st_normal_o, st_snoop_o, st_sleep_o, st_loop_o;
   logic st_busoff_o, st_pex_o;
   logic irq_busoff_on_o, irq_busoff_off_o, irq_pex_o, irq_wake_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   canfd_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_enable_i(cfg_enable_i), .soft_rst_i(soft_rst_i),
      .req_loop_i(req_loop_i), .req_sleep_i(req_sleep_i), .req_snoop_i(req_snoop_i),
      .bit_stb_i(bit_stb_i), .bus_rx_i(bus_rx_i), .tx_err_cnt_i(tx_err_cnt_i),
      .recov_start_i(recov_start_i), .recov_auto_i(recov_auto_i),
      .pex_disable_i(pex_disable_i), .pex_event_i(pex_event_i),
      .st_config_o(st_config_o), .st_normal_o(st_normal_o), .st_snoop_o(st_snoop_o),
      .st_sleep_o(st_sleep_o), .st_loop_o(st_loop_o),
      .st_busoff_o(st_busoff_o), .st_pex_o(st_pex_o),
      .irq_busoff_on_o(irq_busoff_on_o), .irq_busoff_off_o(irq_busoff_off_o),
      .irq_pex_o(irq_pex_o), .irq_wake_o(irq_wake_o)
   );

   logic [4:0] st;
   assign st = {st_config_o, st_normal_o, st_snoop_o, st_sleep_o, st_loop_o};

   // [7]=sleep [6]=loop [5]=snoop requests; [4:0]={cfg,normal,snoop,sleep,loop}
   localparam logic [7:0] VEC [0:7] = '{
      8'b000_01000, 8'b001_00100, 8'b010_00001, 8'b011_00001,
      8'b100_00010, 8'b101_00010, 8'b110_00010, 8'b111_00010
   };

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic rx);
      @(negedge clk);
      bit_stb_i = 1'b1;
      bus_rx_i  = rx;
      @(negedge clk);
      bit_stb_i = 1'b0;
      bus_rx_i  = 1'b1;
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) strobe(1'b1);
   endtask

   task automatic go_mode(input logic s, input logic l, input logic n);
      @(negedge clk);
      cfg_enable_i = 1'b0;
      @(negedge clk);
      req_sleep_i  = s;
      req_loop_i   = l;
      req_snoop_i  = n;
      cfg_enable_i = 1'b1;
      strobes(11);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 reset mode", st, 5'b10000);
      chk("R1 reset busoff/pex/irq",
          {st_busoff_o, st_pex_o, irq_busoff_on_o, irq_busoff_off_o, irq_pex_o, irq_wake_o}, 6'b0);
      rst_n = 1'b1;

      // R2 R3 R4: table walk of request patterns
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         cfg_enable_i = 1'b0;
         @(negedge clk);
         req_sleep_i  = VEC[v][7];
         req_loop_i   = VEC[v][6];
         req_snoop_i  = VEC[v][5];
         cfg_enable_i = 1'b1;
         strobes(10);
         chk("R2 still config after 10", st, 5'b10000);
         strobe(1'b1);
         chk("R3 mode select", st, VEC[v][4:0]);
         chk("R4 one-hot", $countones(st), 1);
      end

      // R2: dominant restarts the run; unstrobed level ignored
      @(negedge clk);
      cfg_enable_i = 1'b0;
      req_sleep_i = 1'b0; req_loop_i = 1'b0; req_snoop_i = 1'b0;
      @(negedge clk);
      cfg_enable_i = 1'b1;
      strobes(6);
      strobe(1'b0);
      @(negedge clk);
      bus_rx_i = 1'b0;
      repeat (3) @(negedge clk);
      bus_rx_i = 1'b1;
      strobes(10);
      chk("R2 dominant restarts run", st, 5'b10000);
      strobe(1'b1);
      chk("R2 exit after full run", st, 5'b01000);

      // R11: request change in active mode has no effect
      @(negedge clk);
      req_sleep_i = 1'b1; req_loop_i = 1'b1;
      repeat (4) @(negedge clk);
      strobes(12);
      chk("R11 mode held", st, 5'b01000);

      // R10: wake from sleep
      go_mode(1'b1, 1'b0, 1'b0);
      chk("R10 in sleep", st, 5'b00010);
      strobe(1'b1);
      chk("R10 recessive keeps sleep", {st, irq_wake_o}, {5'b00010, 1'b0});
      strobe(1'b0);
      chk("R10 wake to normal", {st, irq_wake_o}, {5'b01000, 1'b1});
      @(negedge clk);
      chk("R10 wake irq one cycle", irq_wake_o, 1'b0);

      // R5: no entry in configuration, none at 255
      @(negedge clk);
      cfg_enable_i = 1'b0;
      tx_err_cnt_i = 9'd300;
      repeat (3) @(negedge clk);
      chk("R5 no busoff in config", {st_busoff_o, irq_busoff_on_o}, 2'b00);
      tx_err_cnt_i = '0;
      go_mode(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      tx_err_cnt_i = 9'd255;
      repeat (2) @(negedge clk);
      chk("R5 no busoff at 255", st_busoff_o, 1'b0);
      tx_err_cnt_i = 9'd256;
      @(negedge clk);
      chk("R5 busoff entry", {st_busoff_o, irq_busoff_on_o}, 2'b11);
      tx_err_cnt_i = '0;
      @(negedge clk);
      chk("R5 entry irq one cycle", {st_busoff_o, irq_busoff_on_o}, 2'b10);

      // R6: waits for start without auto
      strobes(11 * 128 + 5);
      chk("R6 no recovery without start", st_busoff_o, 1'b1);
      @(negedge clk);
      recov_start_i = 1'b1;
      @(negedge clk);
      recov_start_i = 1'b0;
      // R7: 128 runs of 11
      strobes(11 * 128 - 1);
      chk("R7 busoff before last strobe", {st_busoff_o, irq_busoff_off_o}, 2'b10);
      strobe(1'b1);
      chk("R7 recovery complete", {st_busoff_o, irq_busoff_off_o}, 2'b01);
      @(negedge clk);
      chk("R7 off irq one cycle", irq_busoff_off_o, 1'b0);

      // R6: auto recovery starts on entry
      recov_auto_i = 1'b1;
      tx_err_cnt_i = 9'd400;
      @(negedge clk);
      tx_err_cnt_i = '0;
      chk("R6 auto entry", st_busoff_o, 1'b1);
      strobes(11 * 128);
      chk("R6 auto recovery complete", {st_busoff_o, irq_busoff_off_o}, 2'b01);
      recov_auto_i = 1'b0;

      // R1: soft reset while waiting in bus-off
      tx_err_cnt_i = 9'd256;
      @(negedge clk);
      tx_err_cnt_i = '0;
      @(negedge clk);
      soft_rst_i = 1'b1;
      @(negedge clk);
      soft_rst_i = 1'b0;
      chk("R1 soft reset clears busoff", {st, st_busoff_o, irq_busoff_off_o}, {5'b10000, 2'b00});

      // R1 R5: soft reset in same cycle as threshold crossing
      go_mode(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      soft_rst_i   = 1'b1;
      tx_err_cnt_i = 9'd300;
      @(negedge clk);
      soft_rst_i   = 1'b0;
      tx_err_cnt_i = '0;
      chk("R1 force wins over busoff entry", {st, st_busoff_o, irq_busoff_on_o}, {5'b10000, 2'b00});

      // R8: exception entry rules
      @(negedge clk);
      pex_event_i = 1'b1;
      @(negedge clk);
      pex_event_i = 1'b0;
      chk("R8 no exception in config", {st_pex_o, irq_pex_o}, 2'b00);
      go_mode(1'b0, 1'b0, 1'b1);
      @(negedge clk);
      pex_disable_i = 1'b1;
      pex_event_i   = 1'b1;
      @(negedge clk);
      pex_event_i   = 1'b0;
      @(negedge clk);
      chk("R8 disabled exception ignored", {st_pex_o, irq_pex_o}, 2'b00);
      pex_disable_i = 1'b0;
      pex_event_i   = 1'b1;
      @(negedge clk);
      pex_event_i   = 1'b0;
      chk("R8 exception entry", {st_pex_o, irq_pex_o}, 2'b11);
      @(negedge clk);
      chk("R8 exception irq one cycle", irq_pex_o, 1'b0);

      // R9: exit after 11 recessive
      strobes(10);
      chk("R9 exception held after 10", st_pex_o, 1'b1);
      strobe(1'b1);
      chk("R9 exception cleared", {st_pex_o, st}, {1'b0, 5'b00100});

      // R1: reset pin mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset pin forces config", st, 5'b10000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 config after reset release", st, 5'b10000);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule